// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block is the command-issuing state machine of a single-bank DDR memory controller. A user presents a three-bit request code together with a row address, a column address and an extended (mode-register) word. The sequencer turns each request into the right series of command-pin values for the row strobe, column strobe and write enable. Beside the command it drives the memory address bus through an internal multiplexer, and it raises read-enable, write-enable and DQS-drive controls for the surrounding data path. A done flag tells the user when the sequencer is free, or that an extended command has completed.

Every registered output is a literal bit field of the state code, so the outputs come straight from flip-flops with no decode stage behind them. Two spare bits keep apart states that would otherwise drive identical outputs. A read or write access always follows the same fixed pattern: one activate, two idle cycles, the column command, a burst wait sized from the burst-length setting, and a closing precharge. This spacing suits a CAS latency of 2. A refresh issues one auto-refresh command and then waits a fixed number of cycles. Only one bank is handled per access, and activates to several banks are never overlapped.

Top module: `ddr_cmd_seq`

## Requirements
- R1: The reset input is synchronous and active high. During reset and in the idle state the command pins read NOP, done is 1, addrSel is 00, memAddr is 0, and rdEn, wrEn and dqsOe are 0.
- R2: The command triple {rasN,casN,weN} uses these encodings: NOP 111, activate 011, write 100, read 101, auto refresh 001, precharge 010, mode-register set 000.
- R3: In idle, request 3'b011 starts a read and 3'b010 starts a write. The sequencer issues activate with addrSel 10 and memAddr equal to rowAddr, then exactly two NOP cycles (addrSel still 10), then the read or write command with addrSel 01 and memAddr equal to colAddr.
- R4: After the read or write command, the sequencer issues NOP for 2^blCode cycles, with addrSel held at 01. This means burst length 2<<blCode, so blCode 1 gives burst length 4 and a 2-cycle wait. It then issues one precharge cycle with addrSel 00 and returns to idle. blCode is captured during the read or write command cycle.
- R5: In idle, request 3'b001 issues one auto-refresh cycle, then REF_DLY NOP cycles (5 by default), then returns to idle.
- R6: In idle, any request with bit 2 set issues one mode-register-set cycle with addrSel 11 and memAddr equal to extAddr, whatever bits 1:0 hold. The sequencer then holds done at 1 with NOP while bit 2 stays high, and returns to idle on the first cycle bit 2 is seen low.
- R7: rdEn is 1 during the read command and its burst wait. wrEn and dqsOe are 1 during the write command and its burst wait. These signals are 0 in every other state, and rdEn never coincides with wrEn.
- R8: Requests presented while an access, a refresh or an extended command is in progress have no effect on the running sequence. A request still present when the sequencer reaches idle starts after exactly one idle cycle.
- R9: Request 3'b000 in idle keeps the sequencer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqCode | input | 3 | User request code |
| blCode | input | 2 | Burst length select, burst length = 2<<blCode |
| rowAddr | input | ADDR_W | Row address for activate |
| colAddr | input | ADDR_W | Column address for read/write |
| extAddr | input | ADDR_W | Word for the mode-register command |
| rasN | output | 1 | Row strobe command bit |
| casN | output | 1 | Column strobe command bit |
| weN | output | 1 | Write-enable command bit |
| memAddr | output | ADDR_W | Multiplexed memory address |
| addrSel | output | 2 | Address source select (00 zero, 10 row, 01 column, 11 extended) |
| rdEn | output | 1 | Read data capture enable |
| wrEn | output | 1 | Write data drive enable |
| dqsOe | output | 1 | DQS output drive enable |
| done | output | 1 | Idle or extended command completed |

## Verification
Two events can fall in the same cycle: the closing edge of one operation, where the precharge or the last refresh-wait cycle returns to idle, and a new request that the user has kept asserted across that edge. The bench provokes this in two ways. It holds a read request steady through a whole access, and it drives conflicting codes while the sequencer is busy, then lowers them only a few cycles before idle. The scoreboard expects every busy-time request to be ignored and a held request to start again after exactly one idle cycle. It checks this cycle by cycle against the command, address, enable and done outputs.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_ACT = 3'b011;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_MRS = 3'b000;

  localparam logic [1:0] SEL_ZERO = 2'b00;
  localparam logic [1:0] SEL_ROW  = 2'b10;
  localparam logic [1:0] SEL_COL  = 2'b01;
  localparam logic [1:0] SEL_EXT  = 2'b11;

  // state code layout: [11:10] spare, [9] refresh phase, [8] read en,
  // [7] write en, [6] dqs drive, [5:4] address select, [3] done, [2:0] command
  typedef enum logic [11:0] {
    S_IDLE = 12'b00_0_000_00_1_111,
    S_ACTW = 12'b01_0_000_10_0_011,
    S_ACTR = 12'b10_0_000_10_0_011,
    S_NW1  = 12'b00_0_000_10_0_111,
    S_NW2  = 12'b01_0_000_10_0_111,
    S_NR1  = 12'b10_0_000_10_0_111,
    S_NR2  = 12'b11_0_000_10_0_111,
    S_WR   = 12'b00_0_011_01_0_100,
    S_RD   = 12'b00_0_100_01_0_101,
    S_BWW  = 12'b00_0_011_01_0_111,
    S_BWR  = 12'b00_0_100_01_0_111,
    S_PRE  = 12'b00_0_000_00_0_010,
    S_REF  = 12'b00_1_000_00_0_001,
    S_REFW = 12'b00_1_000_00_0_111,
    S_EXT  = 12'b00_0_000_11_0_000,
    S_XDN  = 12'b01_0_000_00_1_111
  } seqState_t;

  typedef struct packed {
    logic burstLoad;
    logic burstStep;
    logic refLoad;
    logic refStep;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import ddr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reqCode,
  input  logic       burstEnd,
  input  logic       refDone,
  output logic [2:0] cmd,
  output logic [1:0] addrSel,
  output logic       rdEn,
  output logic       wrEn,
  output logic       dqsOe,
  output logic       done,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = S_IDLE;
    case (state)
      S_IDLE: begin
        if (reqCode[2]) stateNext = S_EXT;
        else begin
          case (reqCode[1:0])
            2'b01:   stateNext = S_REF;
            2'b10:   stateNext = S_ACTW;
            2'b11:   stateNext = S_ACTR;
            default: stateNext = S_IDLE;
          endcase
        end
      end
      S_ACTW: stateNext = S_NW1;
      S_NW1:  stateNext = S_NW2;
      S_NW2:  stateNext = S_WR;
      S_WR:   stateNext = S_BWW;
      S_BWW:  stateNext = burstEnd ? S_PRE : S_BWW;
      S_ACTR: stateNext = S_NR1;
      S_NR1:  stateNext = S_NR2;
      S_NR2:  stateNext = S_RD;
      S_RD:   stateNext = S_BWR;
      S_BWR:  stateNext = burstEnd ? S_PRE : S_BWR;
      S_PRE:  stateNext = S_IDLE;
      S_REF:  stateNext = S_REFW;
      S_REFW: stateNext = refDone ? S_IDLE : S_REFW;
      S_EXT:  stateNext = S_XDN;
      S_XDN:  stateNext = reqCode[2] ? S_XDN : S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  // outputs are the state bits themselves
  assign cmd     = state[2:0];
  assign done    = state[3];
  assign addrSel = state[5:4];
  assign dqsOe   = state[6];
  assign wrEn    = state[7];
  assign rdEn    = state[8];

  assign strobe.burstLoad = (state == S_WR) || (state == S_RD);
  assign strobe.burstStep = (state == S_BWW) || (state == S_BWR);
  assign strobe.refLoad   = (state == S_REF);
  assign strobe.refStep   = (state == S_REFW);

  // R3: column command always three cycles after activate, NOPs between
  a_r3_act_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |->
      ($past(cmd, 3) == CMD_ACT && $past(cmd, 2) == CMD_NOP && $past(cmd, 1) == CMD_NOP));

  // R4: precharge is followed by idle
  a_r4_pre_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |=> (cmd == CMD_NOP && done));

  // R5: auto refresh is followed by a NOP wait
  a_r5_ref_wait: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP && !done));

  // R6: done stays high while the extended request is held
  a_r6_hold_done: assert property (@(posedge clk) disable iff (rst)
    (state == S_XDN && reqCode[2]) |=> (done && cmd == CMD_NOP));

  // R7: read and write enables never overlap
  a_r7_excl: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (!wrEn && !dqsOe));

endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BL_W    = 2,
  parameter int REF_DLY = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [BL_W-1:0]   blCode,
  input  logic [1:0]        addrSel,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [ADDR_W-1:0] colAddr,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              burstEnd,
  output logic              refDone
);

  localparam int BCNT_W = (1 << BL_W) - 1;
  localparam int RCNT_W = $clog2(REF_DLY + 1);

  logic [BCNT_W-1:0] burstCnt;
  logic [BCNT_W-1:0] burstReload;
  logic [RCNT_W-1:0] refCnt;

  // wait cycles = burst length / 2, counter counts down to zero
  assign burstReload = BCNT_W'((1 << blCode) - 1);
  assign burstEnd    = (burstCnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                         burstCnt <= '0;
    else if (strobe.burstLoad)       burstCnt <= burstReload;
    else if (strobe.burstStep && !burstEnd) burstCnt <= burstCnt - 1'b1;
  end

  assign refDone = (refCnt == RCNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                                  refCnt <= '0;
    else if (strobe.refLoad)                  refCnt <= RCNT_W'(REF_DLY);
    else if (strobe.refStep && refCnt != '0)  refCnt <= refCnt - 1'b1;
  end

  always_comb begin
    case (addrSel)
      SEL_ROW: memAddr = rowAddr;
      SEL_COL: memAddr = colAddr;
      SEL_EXT: memAddr = extAddr;
      default: memAddr = '0;
    endcase
  end

  // R5: the refresh wait never steps an exhausted counter
  a_r5_ref_live: assert property (@(posedge clk) disable iff (rst)
    strobe.refStep |-> (refCnt != '0));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BL_W    = 2,
  parameter int REF_DLY = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reqCode,
  input  logic [BL_W-1:0]   blCode,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [ADDR_W-1:0] colAddr,
  input  logic [ADDR_W-1:0] extAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        addrSel,
  output logic              rdEn,
  output logic              wrEn,
  output logic              dqsOe,
  output logic              done
);

  seqStrobe_t strobe;
  logic [2:0] cmd;
  logic       burstEnd;
  logic       refDone;

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqCode  (reqCode),
    .burstEnd (burstEnd),
    .refDone  (refDone),
    .cmd      (cmd),
    .addrSel  (addrSel),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .dqsOe    (dqsOe),
    .done     (done),
    .strobe   (strobe)
  );

  seq_dpath #(
    .ADDR_W  (ADDR_W),
    .BL_W    (BL_W),
    .REF_DLY (REF_DLY)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .blCode   (blCode),
    .addrSel  (addrSel),
    .rowAddr  (rowAddr),
    .colAddr  (colAddr),
    .extAddr  (extAddr),
    .memAddr  (memAddr),
    .burstEnd (burstEnd),
    .refDone  (refDone)
  );

  assign {rasN, casN, weN} = cmd;

endmodule

// File: tb/ddr_cmd_seq_test.sv
module ddr_cmd_seq_test;

  localparam int AW = 13;
  localparam int REFD = 5;
  localparam int WATCHDOG = 50000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    reqCode = 3'b000;
  logic [1:0]    blCode = 2'd1;
  logic [AW-1:0] rowAddr = '0;
  logic [AW-1:0] colAddr = '0;
  logic [AW-1:0] extAddr = '0;
  logic          rasN, casN, weN, rdEn, wrEn, dqsOe, done;
  logic [AW-1:0] memAddr;
  logic [1:0]    addrSel;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ended = 0;

  typedef struct {
    logic [2:0]    cmd;
    logic [1:0]    sel;
    logic          ren, wen, dts, dn;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t q[$];

  ddr_cmd_seq #(.ADDR_W(AW), .BL_W(2), .REF_DLY(REFD)) uut (
    .clk(clk), .rst(rst), .reqCode(reqCode), .blCode(blCode),
    .rowAddr(rowAddr), .colAddr(colAddr), .extAddr(extAddr),
    .rasN(rasN), .casN(casN), .weN(weN), .memAddr(memAddr),
    .addrSel(addrSel), .rdEn(rdEn), .wrEn(wrEn), .dqsOe(dqsOe), .done(done)
  );

  always #5 clk = ~clk;

  task automatic push(input logic [2:0] c, input logic [1:0] s, input logic r,
                      input logic w, input logic d, input logic dn, input string tag);
    exp_t e;
    e.cmd = c; e.sel = s; e.ren = r; e.wen = w; e.dts = d; e.dn = dn; e.tag = tag;
    case (s)
      2'b10:   e.addr = rowAddr;
      2'b01:   e.addr = colAddr;
      2'b11:   e.addr = extAddr;
      default: e.addr = '0;
    endcase
    q.push_back(e);
  endtask

  task automatic pushIdle(input string tag);
    push(3'b111, 2'b00, 0, 0, 0, 1, tag);
  endtask

  // monitor: compares one expected item per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [AW+8:0] act, exv;
        e = q.pop_front();
        act = {rasN, casN, weN, addrSel, rdEn, wrEn, dqsOe, done, memAddr};
        exv = {e.cmd, e.sel, e.ren, e.wen, e.dts, e.dn, e.addr};
        total++;
        if (act !== exv) begin
          bad++;
          $display("FAIL %s: actual cmd=%b sel=%b r/w/dqs=%b%b%b done=%b addr=%h expected cmd=%b sel=%b r/w/dqs=%b%b%b done=%b addr=%h",
                   e.tag, {rasN, casN, weN}, addrSel, rdEn, wrEn, dqsOe, done, memAddr,
                   e.cmd, e.sel, e.ren, e.wen, e.dts, e.dn, e.addr);
        end
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // push the full expected sequence of one access (R3, R4, R7)
  task automatic pushAccess(input bit isRead, input logic [1:0] blc, input bit withIdle);
    push(3'b011, 2'b10, 0, 0, 0, 0, "R3 activate");
    push(3'b111, 2'b10, 0, 0, 0, 0, "R3 nop1");
    push(3'b111, 2'b10, 0, 0, 0, 0, "R3 nop2");
    if (isRead) push(3'b101, 2'b01, 1, 0, 0, 0, "R3/R7 read");
    else        push(3'b100, 2'b01, 0, 1, 1, 0, "R3/R7 write");
    for (int i = 0; i < (1 << blc); i++) begin
      if (isRead) push(3'b111, 2'b01, 1, 0, 0, 0, "R4 burst wait rd");
      else        push(3'b111, 2'b01, 0, 1, 1, 0, "R4 burst wait wr");
    end
    push(3'b010, 2'b00, 0, 0, 0, 0, "R4 precharge");
    if (withIdle) pushIdle("R4 back to idle");
  endtask

  task automatic runAccess(input bit isRead, input logic [1:0] blc, input logic [2:0] junk);
    @(negedge clk);
    blCode = blc;
    reqCode = isRead ? 3'b011 : 3'b010;
    pushAccess(isRead, blc, 1);
    @(negedge clk);
    reqCode = junk;
    if (junk != 3'b000) begin
      // R8: busy-time request ignored, lowered before idle samples it
      while (q.size() > 3) @(negedge clk);
      reqCode = 3'b000;
    end
    drain();
  endtask

  task automatic runRefresh();
    @(negedge clk);
    reqCode = 3'b001;
    push(3'b001, 2'b00, 0, 0, 0, 0, "R5 auto refresh");
    for (int i = 0; i < REFD; i++) push(3'b111, 2'b00, 0, 0, 0, 0, "R5 refresh wait");
    pushIdle("R5 back to idle");
    @(negedge clk);
    reqCode = 3'b000;
    drain();
  endtask

  task automatic runExt(input logic [2:0] code, input int hold);
    int n;
    @(negedge clk);
    reqCode = code;
    push(3'b000, 2'b11, 0, 0, 0, 0, "R6 mode set");
    n = (hold < 2) ? 1 : hold - 1;
    for (int i = 0; i < n; i++) push(3'b111, 2'b00, 0, 0, 0, 1, "R6 done hold");
    pushIdle("R6 back to idle");
    for (int i = 0; i < hold - 1; i++) @(negedge clk);
    @(negedge clk);
    reqCode = 3'b000;
    drain();
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    @(negedge clk);
    pushIdle("R1 reset");
    pushIdle("R1 reset");
    drain();
    rst = 1'b0;

    // R9: code 000 keeps idle
    for (int i = 0; i < 3; i++) pushIdle("R9 idle hold");
    drain();

    rowAddr = 13'h0abc; colAddr = 13'h0012; extAddr = 13'h1555;
    runAccess(1, 2'd1, 3'b000);   // read BL4
    rowAddr = 13'h1f00; colAddr = 13'h00f8;
    runAccess(0, 2'd1, 3'b000);   // write BL4
    runAccess(1, 2'd0, 3'b000);   // read BL2
    runAccess(0, 2'd2, 3'b000);   // write BL8
    runAccess(1, 2'd3, 3'b000);   // read BL16

    runRefresh();

    runExt(3'b100, 1);
    extAddr = 13'h0033;
    runExt(3'b111, 4);            // low bits ignored
    runExt(3'b101, 2);

    // R8: conflicting requests during a busy access
    rowAddr = 13'h0111; colAddr = 13'h0222;
    runAccess(0, 2'd1, 3'b001);
    runAccess(1, 2'd2, 3'b110);

    // R8: held read request restarts after exactly one idle cycle
    @(negedge clk);
    blCode = 2'd1;
    reqCode = 3'b011;
    pushAccess(1, 2'd1, 0);
    pushIdle("R8 single idle between");
    pushAccess(1, 2'd1, 1);
    while (q.size() > 3) @(negedge clk);
    reqCode = 3'b000;
    drain();

    // R1: reset in the middle of an access returns to idle
    @(negedge clk);
    reqCode = 3'b010;
    push(3'b011, 2'b10, 0, 0, 0, 0, "R1 activate before reset");
    push(3'b111, 2'b10, 0, 0, 0, 0, "R1 nop before reset");
    @(negedge clk);
    reqCode = 3'b000;
    @(negedge clk);
    rst = 1'b1;
    pushIdle("R1 mid reset");
    pushIdle("R1 after reset");
    @(negedge clk);
    rst = 1'b0;
    drain();

    // R2: refresh after reset to confirm encodings still hold
    runRefresh();

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule